// File: doc/BRIEF.md
# Banked Interrupt Distributor With 16-Bit Target Maps

This block collects interrupt requests from device lines and from lines private to each CPU. It decides which CPU interfaces each request is shown to, and offers each CPU one interrupt at a time.

Software programs the block through a word-wide register port. The port carries a CPU select, so that each CPU sees its own copy of the state kept for IDs 0 to 31. IDs 0 to 15 are software-generated interrupts, raised by writing a CPU map and an ID to one register. IDs 16 to 31 are private inputs, with one set of 16 lines per CPU. IDs 32 and up are shared device inputs. Each shared input is routed to CPUs through its own 16-bit target bitmap.

Each CPU interface sees the lowest-numbered ID that meets all of these conditions: it is enabled, pending and not active, and, if it is shared, its target bitmap has that CPU's bit set. The CPU takes the shown ID with an acknowledge pulse, which makes it active. It releases the ID with an end-of-interrupt pulse that carries the ID.

Top module: `irq_distributor`

## Requirements
- R1: After reset no CPU sees a valid interrupt, and the following registers read 0: control, every enable word, every pending word and every active word.
- R2: Enable bits sit in word ID/32 at bit ID%32. A write to the set register (0x100 + 4*word) enables each ID whose data bit is 1. A write to the clear register (0x180 + 4*word) disables each ID whose data bit is 1. Data bits of 0 change nothing. Both addresses read back the enable bits.
- R3: Enable, pending and active state for IDs 0–31 is banked. Each access works on the copy selected by `cpu_sel_i`. Private line `priv_irq_i[c*16+j]` drives ID 16+j for CPU c only.
- R4: Each shared ID has a 16-bit target map in the word at 0x400 + 4*(ID/2). An odd ID uses bits 31:16 and an even ID uses bits 15:0. A shared ID is shown to CPU c only if bit c of its map is 1.
- R5: Reading a target word for IDs 0–31 (0x400–0x43C) returns the reading CPU's one-hot bit in both halves. Writes to those words are ignored.
- R6: A write to 0x008 puts the ID in bits 3:0 and a CPU map in bits 23:8. It sets that ID pending on every CPU c whose bit 8+c is 1, and on no other CPU.
- R7: Trigger mode is one bit per ID at 0x380 + 4*(ID/32): 1 means rising edge and 0 means level high. The bits for IDs 0–15 always read 1, and writes to them are ignored.
- R8: The read-only register at 0x004 returns NUM_IDS/32-1 in bits 4:0, and writes to it have no effect.
- R9: Control bit 0 at 0x000 is the global enable. While it is 0, no CPU sees a valid interrupt.
- R10: A level-mode ID is pending while its line is high. An edge-mode ID latches pending on a rising edge, keeps it after the line falls, and loses it when the ID is acknowledged.
- R11: Each CPU sees the lowest ID that is enabled, pending, not active and routed to it, with a valid flag. The outputs follow register state in the cycle after a write and follow level inputs in the same cycle.
- R12: An acknowledge pulse while valid makes the shown ID active, and the ID is no longer shown. An end-of-interrupt pulse with that ID clears active. Active bits read at 0x300 + 4*word.
- R13: Writing 1s to 0x200 + 4*word sets latched pending bits, and writing 1s to 0x280 + 4*word clears them. Both addresses read the pending state, level lines included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cpu_sel_i | input | CPU_W | CPU making the register access |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| dev_irq_i | input | NUM_IDS-32 | Shared device lines, bit k is ID 32+k |
| priv_irq_i | input | NUM_CPUS*16 | Private lines per CPU |
| ack_i | input | NUM_CPUS | Acknowledge the shown ID, one bit per CPU |
| eoi_i | input | NUM_CPUS | End of interrupt, one bit per CPU |
| eoi_id_i | input | NUM_CPUS*ID_W | ID that ends, per CPU |
| irq_vld_o | output | NUM_CPUS | A routed interrupt is shown, per CPU |
| irq_id_o | output | NUM_CPUS*ID_W | Shown ID, per CPU |

## Verification
The hardest state to reach is the combination of banking with the active mask. One shared ID routed to two CPUs, a level ID that is acknowledged while its line stays high, and a software interrupt that is pending on one CPU only must all be present at once. The directed walk builds this step by step: it widens a target map while a line is high, acknowledges without releasing, and raises software interrupts with partial CPU maps. Each step checks what both CPUs see. A random phase then mixes enable, target and line changes on the shared IDs and compares both CPU outputs against a bench model.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned MAP_W    = 16;
    localparam int unsigned PRIV_IDS = 32;
    localparam int unsigned SOFT_IDS = 16;
    localparam int unsigned SOFT_MAP_LSB = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] A_TYPE = 12'h004;
    localparam logic [ADDR_W-1:0] A_SOFT = 12'h008;

    // 128-byte regions selected by address bits 11:7
    localparam logic [4:0] RG_ENSET = 5'h02;
    localparam logic [4:0] RG_ENCLR = 5'h03;
    localparam logic [4:0] RG_PDSET = 5'h04;
    localparam logic [4:0] RG_PDCLR = 5'h05;
    localparam logic [4:0] RG_ACT   = 5'h06;
    localparam logic [4:0] RG_CFG   = 5'h07;
    // target words occupy 0x400-0x7FF (address bits 11:10)
    localparam logic [1:0] RG_TGT   = 2'b01;
endpackage

// File: rtl/irq_dist_lowest.sv
module irq_dist_lowest #(
    parameter  int unsigned W  = 64,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        vld_o = |req_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_dist_view.sv
module irq_dist_view #(
    parameter  int unsigned NUM_IDS = 64,
    localparam int unsigned ID_W    = $clog2(NUM_IDS)
) (
    input  logic               gate_i,
    input  logic [NUM_IDS-1:0] en_i,
    input  logic [NUM_IDS-1:0] pend_i,
    input  logic [NUM_IDS-1:0] act_i,
    input  logic [NUM_IDS-1:0] route_i,
    output logic               vld_o,
    output logic [ID_W-1:0]    id_o
);
    logic [NUM_IDS-1:0] cand;

    assign cand = gate_i ? (en_i & pend_i & ~act_i & route_i) : '0;

    irq_dist_lowest #(.W(NUM_IDS)) u_pick (
        .req_i (cand),
        .vld_o (vld_o),
        .idx_o (id_o)
    );
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter  int unsigned NUM_CPUS = 2,
    parameter  int unsigned NUM_IDS  = 64,
    localparam int unsigned ID_W     = $clog2(NUM_IDS),
    localparam int unsigned CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [CPU_W-1:0]           cpu_sel_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic [REG_W-1:0]           bus_wdata_i,
    input  logic                       bus_we_i,
    output logic [REG_W-1:0]           bus_rdata_o,
    input  logic [NUM_IDS-33:0]        dev_irq_i,
    input  logic [NUM_CPUS*16-1:0]     priv_irq_i,
    input  logic [NUM_CPUS-1:0]        ack_i,
    input  logic [NUM_CPUS-1:0]        eoi_i,
    input  logic [NUM_CPUS*ID_W-1:0]   eoi_id_i,
    output logic [NUM_CPUS-1:0]        irq_vld_o,
    output logic [NUM_CPUS*ID_W-1:0]   irq_id_o
);
    localparam int unsigned NUM_WORDS = NUM_IDS / 32;
    localparam int unsigned TYPE_N    = NUM_WORDS - 1;

    typedef struct packed {
        logic                             ctl;
        logic [NUM_IDS-1:0]               cfg;
        logic [NUM_CPUS-1:0][31:0]        en_p;
        logic [NUM_CPUS-1:0][31:0]        pd_p;
        logic [NUM_CPUS-1:0][31:0]        ac_p;
        logic [NUM_CPUS-1:0][15:0]        pin_p;
        logic [NUM_IDS-1:PRIV_IDS]        en_s;
        logic [NUM_IDS-1:PRIV_IDS]        pd_s;
        logic [NUM_IDS-1:PRIV_IDS]        ac_s;
        logic [NUM_IDS-1:PRIV_IDS]        pin_s;
        logic [NUM_IDS-1:PRIV_IDS][MAP_W-1:0] tgt;
    } st_t;

    st_t st_d, st_q;

    // address decode
    logic [4:0] rgn, widx;
    logic [7:0] tidx;
    logic       in_tgt;
    logic       unused_addr;
    assign rgn    = bus_addr_i[11:7];
    assign widx   = bus_addr_i[6:2];
    assign tidx   = bus_addr_i[9:2];
    assign in_tgt = (bus_addr_i[11:10] == RG_TGT);
    assign unused_addr = ^bus_addr_i[1:0];

    logic wr_ctl, wr_soft, wr_ens, wr_enc, wr_pds, wr_pdc, wr_cfg, wr_tgt;
    assign wr_ctl  = bus_we_i && (bus_addr_i == A_CTRL);
    assign wr_soft = bus_we_i && (bus_addr_i == A_SOFT);
    assign wr_ens  = bus_we_i && (rgn == RG_ENSET);
    assign wr_enc  = bus_we_i && (rgn == RG_ENCLR);
    assign wr_pds  = bus_we_i && (rgn == RG_PDSET);
    assign wr_pdc  = bus_we_i && (rgn == RG_PDCLR);
    assign wr_cfg  = bus_we_i && (rgn == RG_CFG);
    assign wr_tgt  = bus_we_i && in_tgt && (tidx >= 8'd16);

    // effective pending: latched bits plus level-mode lines
    logic [NUM_CPUS-1:0][31:0]  pend_p;
    logic [NUM_IDS-1:PRIV_IDS]  pend_s;
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            pend_p[c] = st_q.pd_p[c] |
                        {priv_irq_i[c*16 +: 16] & ~st_q.cfg[31:16], 16'h0000};
        end
        pend_s = st_q.pd_s | (dev_irq_i & ~st_q.cfg[NUM_IDS-1:PRIV_IDS]);
    end

    // per-CPU presentation
    logic [NUM_CPUS-1:0][ID_W-1:0] pick_id;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [NUM_IDS-PRIV_IDS-1:0] hit_s;
        for (genvar i = PRIV_IDS; i < NUM_IDS; i++) begin : g_route
            assign hit_s[i-PRIV_IDS] = st_q.tgt[i][c];
        end
        irq_dist_view #(.NUM_IDS(NUM_IDS)) u_view (
            .gate_i  (st_q.ctl),
            .en_i    ({st_q.en_s, st_q.en_p[c]}),
            .pend_i  ({pend_s, pend_p[c]}),
            .act_i   ({st_q.ac_s, st_q.ac_p[c]}),
            .route_i ({hit_s, {PRIV_IDS{1'b1}}}),
            .vld_o   (irq_vld_o[c]),
            .id_o    (pick_id[c])
        );
        assign irq_id_o[c*ID_W +: ID_W] = pick_id[c];
    end

    // next state: sets first, then clears, then active set, then active release
    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CPUS; c++) begin
            st_d.pin_p[c] = priv_irq_i[c*16 +: 16];
            for (int j = 0; j < 16; j++) begin
                if (st_q.cfg[16+j] && priv_irq_i[c*16+j] && !st_q.pin_p[c][j])
                    st_d.pd_p[c][16+j] = 1'b1;
            end
        end
        st_d.pin_s = dev_irq_i;
        for (int i = PRIV_IDS; i < NUM_IDS; i++) begin
            if (st_q.cfg[i] && dev_irq_i[i-PRIV_IDS] && !st_q.pin_s[i])
                st_d.pd_s[i] = 1'b1;
        end

        if (wr_ctl) st_d.ctl = bus_wdata_i[0];
        if (wr_soft) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                for (int j = 0; j < SOFT_IDS; j++) begin
                    if (bus_wdata_i[SOFT_MAP_LSB+c] && bus_wdata_i[3:0] == 4'(j))
                        st_d.pd_p[c][j] = 1'b1;
                end
            end
        end
        for (int i = 0; i < PRIV_IDS; i++) begin
            if (widx == 5'd0 && bus_wdata_i[i]) begin
                if (wr_ens) st_d.en_p[cpu_sel_i][i] = 1'b1;
                if (wr_enc) st_d.en_p[cpu_sel_i][i] = 1'b0;
                if (wr_pds) st_d.pd_p[cpu_sel_i][i] = 1'b1;
                if (wr_pdc) st_d.pd_p[cpu_sel_i][i] = 1'b0;
            end
        end
        for (int i = PRIV_IDS; i < NUM_IDS; i++) begin
            if (widx == 5'(i/32) && bus_wdata_i[i%32]) begin
                if (wr_ens) st_d.en_s[i] = 1'b1;
                if (wr_enc) st_d.en_s[i] = 1'b0;
                if (wr_pds) st_d.pd_s[i] = 1'b1;
                if (wr_pdc) st_d.pd_s[i] = 1'b0;
            end
            if (wr_tgt && tidx == 8'(i/2))
                st_d.tgt[i] = bus_wdata_i[16*(i%2) +: 16];
        end
        for (int i = SOFT_IDS; i < NUM_IDS; i++) begin
            if (wr_cfg && widx == 5'(i/32)) st_d.cfg[i] = bus_wdata_i[i%32];
        end

        for (int c = 0; c < NUM_CPUS; c++) begin
            if (ack_i[c] && irq_vld_o[c]) begin
                for (int i = 0; i < PRIV_IDS; i++) begin
                    if (pick_id[c] == ID_W'(i)) begin
                        st_d.pd_p[c][i] = 1'b0;
                        st_d.ac_p[c][i] = 1'b1;
                    end
                end
                for (int i = PRIV_IDS; i < NUM_IDS; i++) begin
                    if (pick_id[c] == ID_W'(i)) begin
                        st_d.pd_s[i] = 1'b0;
                        st_d.ac_s[i] = 1'b1;
                    end
                end
            end
        end
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (eoi_i[c]) begin
                for (int i = 0; i < PRIV_IDS; i++) begin
                    if (eoi_id_i[c*ID_W +: ID_W] == ID_W'(i)) st_d.ac_p[c][i] = 1'b0;
                end
                for (int i = PRIV_IDS; i < NUM_IDS; i++) begin
                    if (eoi_id_i[c*ID_W +: ID_W] == ID_W'(i)) st_d.ac_s[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.cfg <= {{(NUM_IDS-SOFT_IDS){1'b0}}, {SOFT_IDS{1'b1}}};
        end else begin
            st_q <= st_d;
        end
    end

    // read path
    function automatic logic [REG_W-1:0] pick_word(input logic [NUM_IDS-1:0] v,
                                                   input logic [4:0] w);
        logic [REG_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (w == 5'(k)) r = v[k*32 +: 32];
        end
        return r;
    endfunction

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_CTRL) begin
            bus_rdata_o[0] = st_q.ctl;
        end else if (bus_addr_i == A_TYPE) begin
            bus_rdata_o[4:0] = 5'(TYPE_N);
        end else if (in_tgt) begin
            if (tidx < 8'd16) begin
                bus_rdata_o = {2{MAP_W'(1) << cpu_sel_i}};
            end else begin
                for (int i = PRIV_IDS; i < NUM_IDS; i++) begin
                    if (tidx == 8'(i/2)) bus_rdata_o[16*(i%2) +: 16] = st_q.tgt[i];
                end
            end
        end else begin
            case (rgn)
                RG_ENSET, RG_ENCLR:
                    bus_rdata_o = pick_word({st_q.en_s, st_q.en_p[cpu_sel_i]}, widx);
                RG_PDSET, RG_PDCLR:
                    bus_rdata_o = pick_word({pend_s, pend_p[cpu_sel_i]}, widx);
                RG_ACT:
                    bus_rdata_o = pick_word({st_q.ac_s, st_q.ac_p[cpu_sel_i]}, widx);
                RG_CFG:
                    bus_rdata_o = pick_word(st_q.cfg, widx);
                default: bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_dist_checker.sv
module irq_dist_checker
    import irq_dist_pkg::*;
#(
    parameter  int unsigned NUM_CPUS = 2,
    parameter  int unsigned NUM_IDS  = 64,
    localparam int unsigned ID_W     = $clog2(NUM_IDS),
    localparam int unsigned CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [CPU_W-1:0]         cpu_sel_i,
    input logic [ADDR_W-1:0]        bus_addr_i,
    input logic                     wdata0_i,
    input logic                     bus_we_i,
    input logic [REG_W-1:0]         bus_rdata_o,
    input logic [NUM_CPUS-1:0]      ack_i,
    input logic [NUM_CPUS-1:0]      eoi_i,
    input logic [NUM_CPUS-1:0]      irq_vld_o,
    input logic [NUM_CPUS*ID_W-1:0] irq_id_o
);
    // R9: clearing the global enable removes every presentation
    p_gate_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == A_CTRL && !wdata0_i) |=> (irq_vld_o == '0));

    // R8: type register content is fixed
    p_type_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == A_TYPE) |-> (bus_rdata_o[4:0] == 5'(NUM_IDS/32 - 1)));

    // R5: private target words return the reader's own bit
    p_priv_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i[11:10] == RG_TGT && bus_addr_i[9:2] < 8'd16)
        |-> (bus_rdata_o == {2{MAP_W'(1) << cpu_sel_i}}));

    // R7: software-generated IDs always report edge mode
    p_soft_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i[11:7] == RG_CFG && bus_addr_i[6:2] == 5'd0)
        |-> (bus_rdata_o[15:0] == 16'hFFFF));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        // R12: an acknowledged ID is not shown again until released
        p_ack_hides_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ack_i[c] && irq_vld_o[c] && eoi_i == '0)
            |=> !(irq_vld_o[c] &&
                  irq_id_o[c*ID_W +: ID_W] == $past(irq_id_o[c*ID_W +: ID_W])));
    end
endmodule

bind irq_distributor irq_dist_checker #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_sel_i   (cpu_sel_i),
    .bus_addr_i  (bus_addr_i),
    .wdata0_i    (bus_wdata_i[0]),
    .bus_we_i    (bus_we_i),
    .bus_rdata_o (bus_rdata_o),
    .ack_i       (ack_i),
    .eoi_i       (eoi_i),
    .irq_vld_o   (irq_vld_o),
    .irq_id_o    (irq_id_o)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int NI = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [0:0]    cpu_sel = '0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic          we = 1'b0;
    logic [31:0]   rdata;
    logic [31:0]   dev_irq = '0;
    logic [31:0]   priv_irq = '0;
    logic [1:0]    ack = '0;
    logic [1:0]    eoi = '0;
    logic [11:0]   eoi_id = '0;
    logic [1:0]    vld;
    logic [11:0]   id;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_en;
    logic [15:0] m_tgt [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_distributor #(.NUM_CPUS(NC), .NUM_IDS(NI)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cpu_sel_i(cpu_sel), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata),
        .dev_irq_i(dev_irq), .priv_irq_i(priv_irq), .ack_i(ack), .eoi_i(eoi),
        .eoi_id_i(eoi_id), .irq_vld_o(vld), .irq_id_o(id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // eid < 0 means nothing shown
    task automatic chk_irq(input string req, input int c, input int eid);
        logic [31:0] act, exp;
        act = vld[c] ? {25'd0, 1'b1, id[c*IW +: IW]} : 32'd0;
        exp = (eid >= 0) ? {25'd0, 1'b1, 6'(eid)} : 32'd0;
        chk(req, act, exp);
    endtask

    task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'(cpu); addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int cpu, input logic [11:0] a,
                          input logic [31:0] exp);
        @(negedge clk);
        cpu_sel = 1'(cpu); addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_ack(input int c);
        @(negedge clk); ack[c] = 1'b1;
        @(negedge clk); ack[c] = 1'b0;
    endtask

    task automatic do_eoi(input int c, input int eid);
        @(negedge clk); eoi[c] = 1'b1; eoi_id[c*IW +: IW] = 6'(eid);
        @(negedge clk); eoi[c] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dev_irq = '0; priv_irq = '0; ack = '0; eoi = '0; we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int model_pick(input int c);
        for (int i = 32; i < 64; i++) begin
            if (m_en[i] && dev_irq[i-32] && m_tgt[i][c]) return i;
        end
        return -1;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        settle();
        // R1 reset state
        chk_irq("R1 cpu0 idle", 0, -1);
        chk_irq("R1 cpu1 idle", 1, -1);
        rd_chk("R1 control", 0, 12'h000, 32'h0);
        rd_chk("R1 enable word1", 0, 12'h104, 32'h0);
        rd_chk("R1 pending word0", 1, 12'h200, 32'h0);
        rd_chk("R1 active word1", 0, 12'h304, 32'h0);
        rd_chk("R7 cfg word0 reset", 0, 12'h380, 32'h0000FFFF);
        // R8 type register
        rd_chk("R8 type", 0, 12'h004, 32'h1);
        wr(0, 12'h004, 32'h1F);
        rd_chk("R8 type after write", 1, 12'h004, 32'h1);
        // R2 set/clear enables
        wr(0, 12'h104, 32'h5);
        rd_chk("R2 set", 0, 12'h104, 32'h5);
        wr(0, 12'h104, 32'h0);
        rd_chk("R2 zero set no effect", 0, 12'h104, 32'h5);
        wr(1, 12'h184, 32'h1);
        rd_chk("R2 clear", 0, 12'h184, 32'h4);
        wr(0, 12'h184, 32'h0);
        rd_chk("R2 zero clear no effect", 0, 12'h104, 32'h4);
        wr(0, 12'h184, 32'hFFFF_FFFF);
        // R3 banking
        wr(0, 12'h100, 32'h0001_0000);
        rd_chk("R3 other bank untouched", 1, 12'h100, 32'h0);
        rd_chk("R3 own bank", 0, 12'h100, 32'h0001_0000);
        wr(0, 12'h180, 32'h0001_0000);
        // R5 private target words
        rd_chk("R5 cpu1 private target", 1, 12'h400, 32'h0002_0002);
        rd_chk("R5 cpu0 private target", 0, 12'h43C, 32'h0001_0001);
        wr(0, 12'h400, 32'hFFFF_FFFF);
        rd_chk("R5 write ignored", 0, 12'h400, 32'h0001_0001);
        // R4 target packing: id32 -> cpu0, id33 -> cpu1
        wr(0, 12'h440, 32'h0002_0001);
        rd_chk("R4 target readback", 1, 12'h440, 32'h0002_0001);
        // R9 gate off
        wr(0, 12'h104, 32'h3);
        @(negedge clk); dev_irq = 32'h3;
        settle();
        chk_irq("R9 gated cpu0", 0, -1);
        chk_irq("R9 gated cpu1", 1, -1);
        // R11 routing / lowest
        wr(0, 12'h000, 32'h1);
        settle();
        chk_irq("R11 cpu0 sees 32", 0, 32);
        chk_irq("R11 cpu1 sees 33", 1, 33);
        wr(1, 12'h440, 32'h0002_0003);
        settle();
        chk_irq("R11 cpu1 lowest 32", 1, 32);
        chk_irq("R4 cpu0 still 32", 0, 32);
        // R10 level follows line
        @(negedge clk); dev_irq = 32'h2;
        #1;
        chk_irq("R10 level drop cpu0", 0, -1);
        chk_irq("R10 level drop cpu1", 1, 33);
        // R12 ack / eoi
        do_ack(1);
        settle();
        chk_irq("R12 ack hides", 1, -1);
        rd_chk("R12 active bit", 1, 12'h304, 32'h2);
        do_eoi(1, 33);
        settle();
        chk_irq("R12 eoi releases", 1, 33);
        // R7 / R10 edge mode on id34
        wr(0, 12'h384, 32'h4);
        rd_chk("R7 cfg write", 0, 12'h384, 32'h4);
        wr(0, 12'h380, 32'h0);
        rd_chk("R7 soft ids fixed edge", 0, 12'h380, 32'h0000FFFF);
        wr(0, 12'h444, 32'h0000_0001);
        wr(0, 12'h104, 32'h4);
        @(negedge clk); dev_irq = 32'h6;
        @(negedge clk); dev_irq = 32'h2;
        settle();
        chk_irq("R10 edge latched", 0, 34);
        rd_chk("R13 pending read", 0, 12'h204, 32'h6);
        do_ack(0);
        settle();
        chk_irq("R10 ack hides edge", 0, -1);
        do_eoi(0, 34);
        settle();
        chk_irq("R10 edge pending cleared by ack", 0, -1);
        // R6 software interrupts
        wr(0, 12'h100, 32'h20);
        wr(1, 12'h100, 32'h20);
        wr(0, 12'h008, 32'h0000_0305);
        settle();
        chk_irq("R6 cpu0 soft 5", 0, 5);
        chk_irq("R6 cpu1 soft 5", 1, 5);
        rd_chk("R6 pending cpu1", 1, 12'h200, 32'h20);
        do_ack(0);
        settle();
        chk_irq("R12 soft ack cpu0", 0, -1);
        chk_irq("R3 cpu1 bank keeps 5", 1, 5);
        do_ack(1);
        settle();
        chk_irq("R11 cpu1 falls to 33", 1, 33);
        do_eoi(0, 5);
        do_eoi(1, 5);
        wr(0, 12'h100, 32'h8);
        wr(1, 12'h100, 32'h8);
        wr(0, 12'h008, 32'h0000_0103);
        settle();
        chk_irq("R6 map cpu0 only", 0, 3);
        chk_irq("R6 cpu1 not in map", 1, 33);
        // R13 pending clear / set
        wr(0, 12'h280, 32'h8);
        settle();
        chk_irq("R13 pending clear", 0, -1);
        wr(1, 12'h200, 32'h20);
        settle();
        chk_irq("R13 pending set", 1, 5);
        wr(1, 12'h280, 32'h20);
        // R3 private line banked
        wr(1, 12'h100, 32'h0001_0000);
        @(negedge clk); priv_irq = 32'h0001_0000;
        settle();
        chk_irq("R3 private line cpu1", 1, 16);
        chk_irq("R3 private line not cpu0", 0, -1);
        @(negedge clk); priv_irq = '0;

        // random phase on shared IDs (level mode, private IDs disabled)
        do_reset();
        m_en = '0;
        for (int i = 0; i < 64; i++) m_tgt[i] = '0;
        wr(0, 12'h000, 32'h1);
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 4);
            d = $urandom;
            case (op)
                0: begin wr(int'($urandom % 2), 12'h104, d); m_en[63:32] = m_en[63:32] | d; end
                1: begin wr(int'($urandom % 2), 12'h184, d); m_en[63:32] = m_en[63:32] & ~d; end
                2: begin
                    int k;
                    k = 16 + int'($urandom % 16);
                    wr(int'($urandom % 2), 12'h400 + 12'(4*k), d);
                    m_tgt[2*k] = d[15:0];
                    m_tgt[2*k+1] = d[31:16];
                end
                default: begin @(negedge clk); dev_irq = d & $urandom; end
            endcase
            settle();
            chk_irq("R11 random cpu0", 0, model_pick(0));
            chk_irq("R4 random cpu1", 1, model_pick(1));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule